// File: doc/BRIEF.md
# Anti-Alias Filter Band Select and Mute Controller

This block drives the two switch enables that place one of two anti-alias filters in an audio sampling path. The narrow filter has a band of about 8 kHz and the wide filter a band of about 17 kHz. A half-speed mode switch chooses between them. At most one enable is ever high.

Three mute sources override the band choice and turn both enables off. The first is a power-up interval of about seven seconds. It is counted from reset release with a prescaler that is built from the clock-frequency parameter. The second is a hold-mode flag. The third is activity on the delay-time button, which is brought through a two-flop synchroniser first.

Both enables come from one register. Every change at the inputs therefore reaches the pins a fixed number of edges later. For the half-speed switch and the hold flag this is one edge. For the button it is three edges: two synchroniser stages and the output register.

Top module: `aaf_band_ctl`

## Requirements
- R1: With no mute active and `half_speed`=1, the edge after the input is sampled gives `narrow_en`=1 and `wide_en`=0.
- R2: With no mute active and `half_speed`=0, the edge after the input is sampled gives `wide_en`=1 and `narrow_en`=0.
- R3: `narrow_en` and `wide_en` are never both 1.
- R4: After reset release, both enables stay 0 for DIV*MUTE_MS clock edges, where DIV = CLK_HZ/TICK_HZ (at least 1). The selected path is first enabled on edge DIV*MUTE_MS+1. A new reset restarts this interval.
- R5: `hold_on`=1 forces both enables to 0 from the next edge onward, whatever the state of the power-up timer.
- R6: `btn_act` passes through two synchroniser flops. Both enables are 0 from the third edge after `btn_act` rises and stay 0 while it is held. They are still unchanged after the second edge.
- R7: Once every mute source has cleared, the selected path is enabled on the next edge. After `hold_on` falls this is one edge. After `btn_act` falls it is three edges, and the enables are still 0 after two.
- R8: While `rst_n`=0 both enables are 0.
- R9: Once the power-up interval has ended, hold or button muting does not restart it.
- R10: Changes of `half_speed` during a mute have no effect on the enables. When the mute ends, the path chosen by the current `half_speed` value is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous reset, active low, power-on |
| half_speed | input | 1 | 1 selects the narrow path, 0 the wide path |
| hold_on | input | 1 | Hold mode active, mutes both paths |
| btn_act | input | 1 | Delay-time button activity, asynchronous, mutes both paths |
| narrow_en | output | 1 | Enable for the narrow-band filter switch |
| wide_en | output | 1 | Enable for the wide-band filter switch |

## Verification
Two of the block's functions can fall in the same cycle: the end of the power-up interval and an active hold request. The bench provokes this by raising `hold_on` two edges before the edge on which the timer would release the outputs. It then checks that both enables are still 0 on that edge. It also checks that lowering `hold_on` enables the narrow path exactly one edge later, with no second power-up wait. A related pair is a button release and a half-speed change while muted. For this pair the bench checks that the path reflects the latest switch value on the third edge after the release.

// File: rtl/aaf_band_pkg.sv
package aaf_band_pkg;

  typedef enum logic [1:0] {
    BAND_OFF    = 2'b00,
    BAND_NARROW = 2'b01,
    BAND_WIDE   = 2'b10
  } band_e;

  // clock edges per timer tick, never below one
  function automatic int unsigned div_ratio(input int unsigned clk_hz,
                                            input int unsigned tick_hz);
    int unsigned r;
    r = (tick_hz == 0) ? 1 : clk_hz / tick_hz;
    return (r < 1) ? 1 : r;
  endfunction

  // bits needed to hold values 0 .. n-1
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // priority: any mute wins over the band choice
  function automatic band_e pick_band(input logic mute, input logic half);
    if (mute)      return BAND_OFF;
    else if (half) return BAND_NARROW;
    else           return BAND_WIDE;
  endfunction

endpackage

// File: rtl/aaf_sync_chain.sv
module aaf_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic d_in;
    logic q_r;
    if (i == 0) begin : g_first
      assign d_in = d;
    end else begin : g_rest
      assign d_in = g_stage[i-1].q_r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= 1'b0;
      else        q_r <= d_in;
    end
  end

  assign q = g_stage[STAGES-1].q_r;

endmodule

// File: rtl/aaf_powerup_timer.sv
module aaf_powerup_timer #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned TICK_HZ = 1000,
  parameter int unsigned MUTE_MS = 7000
) (
  input  logic clk,
  input  logic rst_n,
  output logic pwr_mute
);

  localparam int unsigned DIV = aaf_band_pkg::div_ratio(CLK_HZ, TICK_HZ);
  localparam int unsigned PW  = aaf_band_pkg::cnt_width(DIV);
  localparam int unsigned MW  = aaf_band_pkg::cnt_width(MUTE_MS + 1);
  localparam logic [PW-1:0] PRESC_LAST = PW'(DIV - 1);
  localparam logic [MW-1:0] MS_LAST    = MW'(MUTE_MS);

  logic [PW-1:0] presc_q;
  logic [MW-1:0] ms_q;
  logic          timer_done;
  logic          tick;

  assign timer_done = (ms_q == MS_LAST);
  assign tick       = !timer_done && (presc_q == PRESC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      ms_q    <= '0;
    end else if (!timer_done) begin
      if (tick) begin
        presc_q <= '0;
        ms_q    <= ms_q + 1'b1;
      end else begin
        presc_q <= presc_q + 1'b1;
      end
    end
  end

  assign pwr_mute = !timer_done;

  // R4: the tick counter never runs past its end value
  assert_ms_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q <= MS_LAST);

  // R9: once ended, the power-up interval never comes back without reset
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timer_done |=> timer_done);

endmodule

// File: rtl/aaf_band_decode.sv
module aaf_band_decode (
  input  logic                pwr_mute,
  input  logic                hold_on,
  input  logic                btn_sync,
  input  logic                half_speed,
  output logic                mute_any,
  output aaf_band_pkg::band_e band_next
);

  assign mute_any  = pwr_mute | hold_on | btn_sync;
  assign band_next = aaf_band_pkg::pick_band(mute_any, half_speed);

endmodule

// File: rtl/aaf_band_ctl.sv
module aaf_band_ctl #(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned TICK_HZ     = 1000,
  parameter int unsigned MUTE_MS     = 7000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_speed,
  input  logic hold_on,
  input  logic btn_act,
  output logic narrow_en,
  output logic wide_en
);

  import aaf_band_pkg::*;

  logic  pwr_mute;
  logic  btn_sync;
  logic  mute_any;
  band_e band_next;
  band_e band_q;

  aaf_powerup_timer #(
    .CLK_HZ (CLK_HZ),
    .TICK_HZ(TICK_HZ),
    .MUTE_MS(MUTE_MS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_mute(pwr_mute)
  );

  aaf_sync_chain #(
    .STAGES(SYNC_STAGES)
  ) u_btn_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (btn_act),
    .q    (btn_sync)
  );

  aaf_band_decode u_decode (
    .pwr_mute  (pwr_mute),
    .hold_on   (hold_on),
    .btn_sync  (btn_sync),
    .half_speed(half_speed),
    .mute_any  (mute_any),
    .band_next (band_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) band_q <= BAND_OFF;
    else        band_q <= band_next;
  end

  assign narrow_en = (band_q == BAND_NARROW);
  assign wide_en   = (band_q == BAND_WIDE);

  assert_one_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({narrow_en, wide_en}));

  assert_narrow_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mute_any && half_speed) |=> (narrow_en && !wide_en));

  assert_wide_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mute_any && !half_speed) |=> (wide_en && !narrow_en));

  assert_pwr_mute_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mute |=> (!narrow_en && !wide_en));

  assert_hold_mute_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_on |=> (!narrow_en && !wide_en));

  assert_btn_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
    btn_sync |=> (!narrow_en && !wide_en));

  assert_reenable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute_any) |=> (narrow_en || wide_en));

endmodule

// File: tb/aaf_band_ctl_bench.sv
module aaf_band_ctl_bench;

  localparam int unsigned T_CLK_HZ  = 4000;
  localparam int unsigned T_TICK_HZ = 1000;
  localparam int unsigned T_MUTE_MS = 10;
  localparam int unsigned T_DIV     = T_CLK_HZ / T_TICK_HZ;
  localparam int unsigned PWR_EDGES = T_DIV * T_MUTE_MS; // 40

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_speed = 1'b0;
  logic hold_on = 1'b0;
  logic btn_act = 1'b0;
  logic narrow_en;
  logic wide_en;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  aaf_band_ctl #(
    .CLK_HZ (T_CLK_HZ),
    .TICK_HZ(T_TICK_HZ),
    .MUTE_MS(T_MUTE_MS)
  ) u_aaf_band_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_speed(half_speed),
    .hold_on   (hold_on),
    .btn_act   (btn_act),
    .narrow_en (narrow_en),
    .wide_en   (wide_en)
  );

  // vector: {req[3:0], half, hold, btn, exp_narrow, exp_wide}
  localparam int NV = 10;
  localparam logic [8:0] VEC [NV] = '{
    {4'd1,  5'b10010},
    {4'd2,  5'b00001},
    {4'd5,  5'b01000},
    {4'd5,  5'b11000},
    {4'd6,  5'b10100},
    {4'd6,  5'b00100},
    {4'd5,  5'b11100},
    {4'd7,  5'b00001},
    {4'd1,  5'b10010},
    {4'd10, 5'b00001}
  };

  task automatic check(input string req, input logic exp_n, input logic exp_w);
    checks++;
    if (narrow_en !== exp_n || wide_en !== exp_w || (narrow_en && wide_en)) begin
      failures++;
      $display("FAIL %s: got narrow=%b wide=%b exp narrow=%b wide=%b",
               req, narrow_en, wide_en, exp_n, exp_w);
    end
  endtask

  task automatic edge_n(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R8: outputs low in reset, whatever the switch does
    edge_n(2);
    half_speed = 1'b1;
    edge_n(1);
    check("R8 reset half=1", 1'b0, 1'b0);
    half_speed = 1'b0;
    edge_n(1);
    check("R8 reset half=0", 1'b0, 1'b0);

    // R4 power-up interval, R10 switch changes while muted
    half_speed = 1'b1;
    rst_n = 1'b1;
    for (int e = 1; e <= PWR_EDGES; e++) begin
      edge_n(1);
      if (e == 10) half_speed = 1'b0;
      if (e == 20) begin
        check("R10 half toggled during power-up", 1'b0, 1'b0);
        half_speed = 1'b1;
      end
    end
    check("R4 last muted edge", 1'b0, 1'b0);
    edge_n(1);
    check("R4 first enabled edge", 1'b1, 1'b0);

    // table walk, each vector settled for three edges
    for (int i = 0; i < NV; i++) begin
      half_speed = VEC[i][4];
      hold_on    = VEC[i][3];
      btn_act    = VEC[i][2];
      edge_n(3);
      check($sformatf("R%0d table[%0d]", VEC[i][8:5], i), VEC[i][1], VEC[i][0]);
    end
    // table ends with wide selected, no mute

    // R1 / R2: one-edge switch latency
    half_speed = 1'b1;
    edge_n(1);
    check("R1 narrow one edge after switch", 1'b1, 1'b0);
    half_speed = 1'b0;
    edge_n(1);
    check("R2 wide one edge after switch", 1'b0, 1'b1);

    // R5 / R7 / R9: hold latency and no power-up restart
    hold_on = 1'b1;
    edge_n(1);
    check("R5 hold mutes next edge", 1'b0, 1'b0);
    hold_on = 1'b0;
    edge_n(1);
    check("R9 R7 re-enable one edge after hold", 1'b0, 1'b1);

    // R6: button synchroniser latency
    btn_act = 1'b1;
    edge_n(2);
    check("R6 still enabled after two edges", 1'b0, 1'b1);
    edge_n(1);
    check("R6 muted on third edge", 1'b0, 1'b0);
    edge_n(5);
    check("R6 muted while held", 1'b0, 1'b0);
    half_speed = 1'b1;  // R10: change while muted
    btn_act = 1'b0;
    edge_n(2);
    check("R7 still muted two edges after release", 1'b0, 1'b0);
    edge_n(1);
    check("R7 R10 narrow on third edge after release", 1'b1, 1'b0);

    // second reset: R4 restart, coincident power-up end and hold (R5)
    rst_n = 1'b0;
    edge_n(1);
    check("R8 reset again", 1'b0, 1'b0);
    rst_n = 1'b1;
    for (int e = 1; e <= PWR_EDGES + 1; e++) begin
      edge_n(1);
      if (e == 20) check("R4 interval restarted by reset", 1'b0, 1'b0);
      if (e == PWR_EDGES - 1) hold_on = 1'b1;
    end
    check("R5 hold at power-up end", 1'b0, 1'b0);
    hold_on = 1'b0;
    edge_n(1);
    check("R7 narrow after hold at power-up end", 1'b1, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule